// File: doc/BRIEF.md
# MSK Carrier Mixer and Symbol Clock

This block is the front end of a minimum-shift-keying receiver that runs on real audio-rate samples at 12.5 kHz. A phase accumulator serves as a numerically controlled oscillator. Its per-sample advance is a nominal 1800 Hz step plus a signed correction word, which a tracking loop elsewhere supplies. Each accepted sample is multiplied by the cosine and by the negated sine of the advanced phase. The complex result goes into an 11-slot circular history that a matched filter downstream reads in full.

A second accumulator advances by the same corrected step and produces the symbol timing. When it crosses a threshold that depends on the step, the block pulses a strobe. With the strobe it gives a sub-sample offset from 0 to 12, which tells the filter which oversampled coefficient phase to use. Filtering, bit decisions and the loop filter are not part of this block.

Top module: `msk_nco_front`

## Requirements
- R1: While `rst_n` is low, and for two clock edges after it rises, the write index is 0, the strobe is low, the offset is 0 and all 11 history entries are zero. Both accumulators restart from zero, so the first accepted sample is mixed at phase equal to one step.
- R2: The step is 9437 (that is, 1800/12500 of a full turn, where a turn is 65536) plus the 13-bit two's-complement `freq_corr_i`, which must keep the step in 1..32767. The oscillator phase is 16 bits and wraps modulo 65536. It is advanced before the sample is mixed. The symbol accumulator uses the same step.
- R3: An accepted sample is written to the slot given by `wr_idx_o` before that sample. The index then advances by one and goes from 10 back to 0. Slot k is at bits [k*24 +: 24] of each history output.
- R4: The real part is x*C and the imaginary part is -(x*S), both 24-bit signed. C and S are round-half-away-from-zero of 2047*cos and 2047*sin of 2*pi*(m+0.5)/1024, where m is phase[15:6].
- R5: The symbol accumulator adds the step on every accepted sample. When the sum is at least 49152 - floor(step/2), 49152 (three quarters of a turn) is subtracted, and `sym_stb_o` is high for exactly the one cycle that follows that sample's clock edge.
- R6: On a strobe, `sym_ofs_o` = min(12, floor(12*(2*a + step)/(2*step))), where a is the accumulator after the subtraction. Between strobes the offset keeps its last value.
- R7: A cycle without `smp_valid_i` changes no output: index, history and offset hold, and the strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| smp_valid_i | input | 1 | Sample accepted this cycle |
| smp_i | input | 12 | Signed input sample |
| freq_corr_i | input | 13 | Signed step correction from the tracking loop |
| buf_re_o | output | 264 | Real parts of the 11 history slots, 24 bits each |
| buf_im_o | output | 264 | Imaginary parts of the 11 history slots, 24 bits each |
| wr_idx_o | output | 4 | Slot the next sample will be written to |
| sym_stb_o | output | 1 | One-cycle symbol strobe |
| sym_ofs_o | output | 4 | Sub-sample filter offset, 0..12 |

## Verification
The hardest case to reach is the clamp of the offset at 12. With a constant step the remainder after the subtraction always stays below half a step, so the offset tops out at 11. Reaching 12 needs the step to grow between the sample before a crossing and the crossing sample itself. The stimulus therefore alternates the correction word between its negative and positive extremes on consecutive samples, and also sweeps it as a ramp. This is mixed with gapped valid patterns, full-scale samples of both signs, and a reset in the middle of the run.

// File: rtl/msk_nco_pkg.sv
package msk_nco_pkg;

  localparam real TWO_PI = 6.283185307179586;

  // Rounded phase increment for a tone, with 2**pw as one full turn.
  function automatic int nominal_step(int tone_hz, int rate_hz, int pw);
    longint num;
    num = (longint'(tone_hz) << pw) + longint'(rate_hz / 2);
    return int'(num / longint'(rate_hz));
  endfunction

  // Magnitude of one quarter-wave table entry, sampled mid-bin.
  function automatic int quarter_mag(int i, int aw, int amp);
    real ang;
    ang = TWO_PI * (real'(i) + 0.5) / real'(4 << aw);
    return $rtoi(real'(amp) * $sin(ang) + 0.5);
  endfunction

endpackage

// File: rtl/msk_sin_lookup.sv
module msk_sin_lookup
  import msk_nco_pkg::*;
#(
  parameter int LUT_AW = 8,
  parameter int AMP_W  = 12
) (
  input  logic [LUT_AW+1:0]       phase_i,
  output logic signed [AMP_W-1:0] value_o
);

  localparam int QDEPTH = 1 << LUT_AW;
  localparam int AMP    = (1 << (AMP_W - 1)) - 1;
  localparam int MAG_W  = AMP_W - 1;

  logic [MAG_W-1:0]  tbl [QDEPTH];
  logic [1:0]        quad;
  logic [LUT_AW-1:0] addr;
  logic [MAG_W-1:0]  mag;

  for (genvar g = 0; g < QDEPTH; g++) begin : g_tbl
    assign tbl[g] = MAG_W'(quarter_mag(g, LUT_AW, AMP));
  end

  always_comb begin
    quad = phase_i[LUT_AW+1 -: 2];
    addr = phase_i[LUT_AW-1:0];
    if (quad[0]) addr = ~addr;
    mag = tbl[addr];
    value_o = quad[1] ? -$signed({1'b0, mag}) : $signed({1'b0, mag});
  end

endmodule

// File: rtl/msk_mixer.sv
module msk_mixer #(
  parameter int SAMPLE_W  = 12,
  parameter int PHASE_W   = 16,
  parameter int LUT_AW    = 8,
  parameter int AMP_W     = 12,
  parameter int BUF_DEPTH = 11,
  parameter int IDX_W     = 4,
  parameter int PROD_W    = 24
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          en_i,
  input  logic signed [SAMPLE_W-1:0]    sample_i,
  input  logic [PHASE_W-1:0]            step_i,
  output logic [BUF_DEPTH*PROD_W-1:0]   buf_re_o,
  output logic [BUF_DEPTH*PROD_W-1:0]   buf_im_o,
  output logic [IDX_W-1:0]              idx_o
);

  localparam int LW = LUT_AW + 2;
  localparam logic [LW-1:0] QTR = LW'(1 << LUT_AW);

  logic [PHASE_W-1:0]       phase_q, phase_d, phase_adv;
  logic [IDX_W-1:0]         idx_q, idx_d;
  logic [LW-1:0]            sin_addr, cos_addr;
  logic signed [AMP_W-1:0]  sin_val, cos_val;
  logic signed [PROD_W-1:0] prod_re, prod_im;

  // next state
  always_comb begin
    phase_adv = phase_q + step_i;
    phase_d   = en_i ? phase_adv : phase_q;
    sin_addr  = phase_adv[PHASE_W-1 -: LW];
    cos_addr  = sin_addr + QTR;
    if (!en_i)                              idx_d = idx_q;
    else if (idx_q == IDX_W'(BUF_DEPTH-1))  idx_d = '0;
    else                                    idx_d = idx_q + IDX_W'(1);
  end

  msk_sin_lookup #(.LUT_AW(LUT_AW), .AMP_W(AMP_W)) u_sin (
    .phase_i (sin_addr),
    .value_o (sin_val)
  );

  msk_sin_lookup #(.LUT_AW(LUT_AW), .AMP_W(AMP_W)) u_cos (
    .phase_i (cos_addr),
    .value_o (cos_val)
  );

  always_comb begin
    prod_re = PROD_W'(sample_i) * PROD_W'(cos_val);
    prod_im = -(PROD_W'(sample_i) * PROD_W'(sin_val));
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
      idx_q   <= '0;
    end else begin
      phase_q <= phase_d;
      idx_q   <= idx_d;
    end
  end

  for (genvar g = 0; g < BUF_DEPTH; g++) begin : g_slot
    logic                     slot_we;
    logic signed [PROD_W-1:0] re_q, im_q;

    assign slot_we = en_i && (idx_q == IDX_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        re_q <= '0;
        im_q <= '0;
      end else if (slot_we) begin
        re_q <= prod_re;
        im_q <= prod_im;
      end
    end

    assign buf_re_o[g*PROD_W +: PROD_W] = re_q;
    assign buf_im_o[g*PROD_W +: PROD_W] = im_q;
  end

  assign idx_o = idx_q;

endmodule

// File: rtl/msk_bitclock.sv
module msk_bitclock #(
  parameter int PHASE_W  = 16,
  parameter int STEP_W   = 17,
  parameter int OVERSAMP = 12,
  parameter int OFS_W    = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     en_i,
  input  logic signed [STEP_W-1:0] step_i,
  output logic                     stb_o,
  output logic [OFS_W-1:0]         ofs_o
);

  localparam int CLK_W = PHASE_W + 3;
  localparam int CMP_W = PHASE_W + 10;
  localparam logic signed [CLK_W-1:0] THR_C = CLK_W'(3 << (PHASE_W - 2));
  localparam logic signed [CMP_W-1:0] OS_C  = CMP_W'(OVERSAMP);

  logic signed [CLK_W-1:0] acc_q, acc_d, acc_sum, acc_wrap, thr;
  logic signed [CMP_W-1:0] numer, step_ext;
  logic [OVERSAMP-1:0]     hit;
  logic [OFS_W-1:0]        ofs_cnt, ofs_q, ofs_d;
  logic                    fire, stb_q, stb_d;

  // next state
  always_comb begin
    acc_sum  = acc_q + CLK_W'(step_i);
    thr      = THR_C - CLK_W'(step_i >>> 1);
    fire     = (acc_sum >= thr);
    acc_wrap = acc_sum - THR_C;
    acc_d    = !en_i ? acc_q : (fire ? acc_wrap : acc_sum);
    step_ext = CMP_W'(step_i);
    numer    = OS_C * ((CMP_W'(acc_wrap) <<< 1) + step_ext);
  end

  // offset = number of thresholds k*2*step (k = 1..OVERSAMP) at or below numer
  for (genvar g = 0; g < OVERSAMP; g++) begin : g_cmp
    localparam logic signed [CMP_W-1:0] K2 = CMP_W'(2 * (g + 1));
    assign hit[g] = (numer >= K2 * step_ext);
  end

  always_comb begin
    ofs_cnt = '0;
    for (int k = 0; k < OVERSAMP; k++) ofs_cnt = ofs_cnt + OFS_W'(hit[k]);
    stb_d = en_i && fire;
    ofs_d = stb_d ? ofs_cnt : ofs_q;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      stb_q <= 1'b0;
      ofs_q <= '0;
    end else begin
      acc_q <= acc_d;
      stb_q <= stb_d;
      ofs_q <= ofs_d;
    end
  end

  assign stb_o = stb_q;
  assign ofs_o = ofs_q;

endmodule

// File: rtl/msk_nco_front.sv
module msk_nco_front
  import msk_nco_pkg::*;
#(
  parameter int SAMPLE_W  = 12,
  parameter int CORR_W    = 13,
  parameter int PHASE_W   = 16,
  parameter int LUT_AW    = 8,
  parameter int AMP_W     = 12,
  parameter int BUF_DEPTH = 11,
  parameter int OVERSAMP  = 12,
  parameter int TONE_HZ   = 1800,
  parameter int RATE_HZ   = 12500,
  localparam int PROD_W   = SAMPLE_W + AMP_W,
  localparam int IDX_W    = $clog2(BUF_DEPTH),
  localparam int OFS_W    = $clog2(OVERSAMP + 1)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        smp_valid_i,
  input  logic signed [SAMPLE_W-1:0]  smp_i,
  input  logic signed [CORR_W-1:0]    freq_corr_i,
  output logic [BUF_DEPTH*PROD_W-1:0] buf_re_o,
  output logic [BUF_DEPTH*PROD_W-1:0] buf_im_o,
  output logic [IDX_W-1:0]            wr_idx_o,
  output logic                        sym_stb_o,
  output logic [OFS_W-1:0]            sym_ofs_o
);

  localparam int STEP_W = PHASE_W + 1;
  localparam int NOM    = nominal_step(TONE_HZ, RATE_HZ, PHASE_W);

  logic                     rst_meta_q, rst_sync_q;
  logic signed [STEP_W-1:0] step;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  // one step feeds both the carrier oscillator and the symbol clock
  assign step = STEP_W'(NOM) + STEP_W'(freq_corr_i);

  msk_mixer #(
    .SAMPLE_W (SAMPLE_W),
    .PHASE_W  (PHASE_W),
    .LUT_AW   (LUT_AW),
    .AMP_W    (AMP_W),
    .BUF_DEPTH(BUF_DEPTH),
    .IDX_W    (IDX_W),
    .PROD_W   (PROD_W)
  ) u_mix (
    .clk     (clk),
    .rst_n   (rst_sync_q),
    .en_i    (smp_valid_i),
    .sample_i(smp_i),
    .step_i  (step[PHASE_W-1:0]),
    .buf_re_o(buf_re_o),
    .buf_im_o(buf_im_o),
    .idx_o   (wr_idx_o)
  );

  msk_bitclock #(
    .PHASE_W (PHASE_W),
    .STEP_W  (STEP_W),
    .OVERSAMP(OVERSAMP),
    .OFS_W   (OFS_W)
  ) u_bclk (
    .clk   (clk),
    .rst_n (rst_sync_q),
    .en_i  (smp_valid_i),
    .step_i(step),
    .stb_o (sym_stb_o),
    .ofs_o (sym_ofs_o)
  );

endmodule

// File: rtl/msk_nco_front_chk.sv
module msk_nco_front_chk #(
  parameter int BUF_DEPTH = 11,
  parameter int OVERSAMP  = 12,
  parameter int IDX_W     = 4,
  parameter int OFS_W     = 4,
  parameter int BUS_W     = 264
) (
  input logic             clk,
  input logic             rst_n,
  input logic             smp_valid_i,
  input logic [BUS_W-1:0] buf_re_o,
  input logic [BUS_W-1:0] buf_im_o,
  input logic [IDX_W-1:0] wr_idx_o,
  input logic             sym_stb_o,
  input logic [OFS_W-1:0] sym_ofs_o
);

  a_r3_idx_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    wr_idx_o < IDX_W'(BUF_DEPTH));

  a_r3_idx_advance: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid_i |=> wr_idx_o ==
      (($past(wr_idx_o) == IDX_W'(BUF_DEPTH-1)) ? '0 : $past(wr_idx_o) + IDX_W'(1)));

  a_r7_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_valid_i |=> !sym_stb_o && $stable(wr_idx_o) && $stable(sym_ofs_o)
                     && $stable(buf_re_o) && $stable(buf_im_o));

  a_r6_ofs_bound: assert property (@(posedge clk) disable iff (!rst_n)
    sym_ofs_o <= OFS_W'(OVERSAMP));

  a_r5_stb_follows_sample: assert property (@(posedge clk) disable iff (!rst_n)
    sym_stb_o |-> $past(smp_valid_i));

endmodule

bind msk_nco_front msk_nco_front_chk #(
  .BUF_DEPTH(BUF_DEPTH),
  .OVERSAMP (OVERSAMP),
  .IDX_W    (IDX_W),
  .OFS_W    (OFS_W),
  .BUS_W    (BUF_DEPTH*PROD_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_q),
  .smp_valid_i(smp_valid_i),
  .buf_re_o   (buf_re_o),
  .buf_im_o   (buf_im_o),
  .wr_idx_o   (wr_idx_o),
  .sym_stb_o  (sym_stb_o),
  .sym_ofs_o  (sym_ofs_o)
);

// File: tb/msk_nco_front_tb.sv
`timescale 1ns/1ps
module msk_nco_front_tb;

  localparam int DEPTH = 11;
  localparam int PW    = 24;
  localparam int NOM   = 9437;
  localparam int TURN3 = 49152;
  localparam real TWO_PI = 6.283185307179586;

  logic               clk = 1'b0;
  logic               rst_n;
  logic               smp_valid_i;
  logic signed [11:0] smp_i;
  logic signed [12:0] freq_corr_i;
  logic [DEPTH*PW-1:0] buf_re_o, buf_im_o;
  logic [3:0]         wr_idx_o;
  logic               sym_stb_o;
  logic [3:0]         sym_ofs_o;

  always #4 clk = ~clk;

  msk_nco_front u_dut (
    .clk(clk), .rst_n(rst_n), .smp_valid_i(smp_valid_i), .smp_i(smp_i),
    .freq_corr_i(freq_corr_i), .buf_re_o(buf_re_o), .buf_im_o(buf_im_o),
    .wr_idx_o(wr_idx_o), .sym_stb_o(sym_stb_o), .sym_ofs_o(sym_ofs_o)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // behavioural reference state
  int ref_ph, ref_acc, ref_idx, ref_stb, ref_ofs;
  int ref_re [DEPTH];
  int ref_im [DEPTH];
  bit last_valid, last_corr_nz, after_reset;
  int lfsr = 16'hACE1;
  int clamp_seen = 0;

  function automatic int table_val(int m, bit use_cos);
    real x;
    x = TWO_PI * (real'(m) + 0.5) / 1024.0;
    x = 2047.0 * (use_cos ? $cos(x) : $sin(x));
    return (x >= 0.0) ? $rtoi(x + 0.5) : -$rtoi(-x + 0.5);
  endfunction

  task automatic ref_reset();
    ref_ph = 0; ref_acc = 0; ref_idx = 0; ref_stb = 0; ref_ofs = 0;
    for (int k = 0; k < DEPTH; k++) begin ref_re[k] = 0; ref_im[k] = 0; end
    after_reset = 1;
  endtask

  task automatic ref_sample(int x, int corr);
    int stp, m, o;
    stp = NOM + corr;                          // R2
    ref_ph = (ref_ph + stp) % 65536;
    m = ref_ph / 64;
    ref_re[ref_idx] = x * table_val(m, 1'b1);  // R4
    ref_im[ref_idx] = -(x * table_val(m, 1'b0));
    ref_idx = (ref_idx + 1) % DEPTH;           // R3
    ref_acc = ref_acc + stp;                   // R5
    if (ref_acc >= TURN3 - stp / 2) begin
      ref_acc = ref_acc - TURN3;
      ref_stb = 1;
      o = (12 * (2 * ref_acc + stp)) / (2 * stp);  // R6
      if (o > 12) begin o = 12; clamp_seen++; end
      ref_ofs = o;
    end else begin
      ref_stb = 0;
    end
  endtask

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic compare();
    string tb_tag;
    if (after_reset)       tb_tag = "R1";
    else if (!last_valid)  tb_tag = "R7";
    else if (last_corr_nz) tb_tag = "R2";
    else                   tb_tag = "R4";
    check(after_reset ? "R1" : "R3", "write index", int'(wr_idx_o), ref_idx);
    check(after_reset ? "R1" : "R5", "strobe", int'(sym_stb_o), ref_stb);
    check(after_reset ? "R1" : "R6", "offset", int'(sym_ofs_o), ref_ofs);
    for (int k = 0; k < DEPTH; k++) begin
      check(tb_tag, $sformatf("re[%0d]", k), int'($signed(buf_re_o[k*PW +: PW])), ref_re[k]);
      check(tb_tag, $sformatf("im[%0d]", k), int'($signed(buf_im_o[k*PW +: PW])), ref_im[k]);
    end
  endtask

  // one cycle: compare what the last edge produced, then present new inputs
  task automatic cycle(bit v, int x, int corr);
    @(negedge clk);
    compare();
    after_reset = 0;
    smp_valid_i = v;
    smp_i = 12'(x);
    freq_corr_i = 13'(corr);
    last_valid = v;
    last_corr_nz = (corr != 0);
    if (v) ref_sample(x, corr);
    else   ref_stb = 0;
  endtask

  function automatic int next_lfsr(int s);
    return ((s >> 1) ^ ((s & 1) ? 16'hB400 : 0)) & 16'hFFFF;
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; smp_valid_i = 1'b0; smp_i = '0; freq_corr_i = '0;
    ref_reset();
    last_valid = 0;
    @(negedge clk);
    compare();                 // R1: state while reset is held
    after_reset = 1;
    rst_n = 1'b1;
    repeat (3) begin           // internal release takes two edges; R1
      @(negedge clk);
      compare();
      after_reset = 1;
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0; smp_valid_i = 1'b0; smp_i = '0; freq_corr_i = '0;
    ref_reset();
    do_reset();

    // R2/R4/R5: nominal step, full-scale positive input, back to back
    for (int i = 0; i < 200; i++) cycle(1'b1, 2047, 0);

    // R7: gapped valid with most-negative input
    for (int i = 0; i < 300; i++) begin
      lfsr = next_lfsr(lfsr);
      cycle(lfsr[0], -2048, 0);
    end

    // R6: correction jumps between extremes so the offset reaches its clamp
    for (int i = 0; i < 400; i++) begin
      lfsr = next_lfsr(lfsr);
      cycle(1'b1, (lfsr & 12'hFFF) - 2048, (i % 2) ? 4000 : -4000);
    end

    // R2: slow ramp of the correction with random samples and gaps
    for (int i = 0; i < 400; i++) begin
      lfsr = next_lfsr(lfsr);
      cycle(lfsr[3] | lfsr[5], (lfsr & 12'hFFF) - 2048, (i * 20) - 4000);
    end

    // R1: reset in the middle of activity, then resume
    do_reset();
    for (int i = 0; i < 60; i++) begin
      lfsr = next_lfsr(lfsr);
      cycle(1'b1, (lfsr & 12'hFFF) - 2048, 1234);
    end
    cycle(1'b0, 0, 0);

    $display("info: offset clamp cases exercised = %0d", clamp_seen);
    done = 1;
    finish_run();
  end

endmodule